// File: doc/BRIEF.md
# Event Timer with Four Compare Channels

The block keeps a free-running 24-bit time counter and four compare channels that watch it. Each channel holds a 24-bit compare value. On the cycle where the counter equals that value, the channel emits a one-cycle match pulse and sets its status flag. A single interrupt line is raised whenever a set status flag has its mask bit enabled. The per-channel match pulses are exported so that neighbouring logic can start its own actions at a scheduled time.

A host reaches the block through a plain word-wide register port with write strobe, read strobe, address and data. Through it the host can:
- read the current time in two halves;
- load each compare value as an upper and a lower word;
- set per-channel disable bits and interrupt masks;
- read the status flags, which clear on read.

A compare value is loaded in two writes. To keep a half-loaded value from firing, writing a channel's upper word silences that channel until its lower word has been written. A channel left enabled fires again each time the counter wraps.

Top module: `evt_timer_cmp`

## Requirements
- R1: The time counter clears to zero in reset. It then increases by one on every clock, wrapping from all ones to zero.
- R2: The `match_pulse[i]` output is high only while the counter equals channel i's compare value, that channel is enabled and it is not inhibited. Since the counter moves every cycle, each match lasts exactly one cycle.
- R3: Writing channel i's upper compare word (address 8+2i) inhibits that channel. The inhibit covers that write cycle and every cycle up to and including the cycle in which its lower compare word (address 9+2i) is written. The channel matches again from the following cycle.
- R4: Writing only the lower compare word changes just the low word bits of the compare value, keeps the upper bits, and causes no inhibit.
- R5: A match sets status bit i whether or not the channel is masked. `irq` is high exactly when some status bit is set and the mask register (address 2) has the same bit position i set.
- R6: Writing the disable register (address 3) with bit i = 1 disables channel i and clears status bit i. A disabled channel never matches.
- R7: After reset, every channel is enabled (disable register reads 0), the mask register reads 0, and `irq` stays low. All compare values reset to zero, so every channel flags a match at counter value 0.
- R8: Reading the status register (address 4) returns the flags in bits i and then clears them. A match for channel i in the same cycle as that read leaves bit i set.
- R9: Reading address 0 returns the counter bits above the low word, and in the same cycle captures the counter's low word. Address 1 then returns that captured low word, so both halves come from one instant.
- R10: An enabled channel whose compare value is not rewritten matches once per full counter period: two matches in any window of two periods.
- R11: Read data appears on `rdata` the cycle after the read strobe. Compare words read back at their own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Read data, registered |
| irq | output | 1 | Masked interrupt request |
| match_pulse | output | NCH | One-cycle match indication per channel |

## Verification
The bench builds the block with a 10-bit counter and a 6-bit word, keeping NCH=4 and ADDR_W=4. One counter period is then 1024 cycles, so the bench can watch whole periods and wraps, and sweep every channel through windows of two full periods. Every cycle in those windows is compared against a counter model kept in the bench. With a 4-bit upper part and 6-bit lower word, the split time read and the upper/lower compare loads still exercise a real word boundary.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned A_TIME_HI  = 0;
  localparam int unsigned A_TIME_LO  = 1;
  localparam int unsigned A_MASK     = 2;
  localparam int unsigned A_DIS      = 3;
  localparam int unsigned A_STAT     = 4;
  localparam int unsigned A_CMP_BASE = 8;

  function automatic int unsigned cmp_hi_addr(input int unsigned ch);
    return A_CMP_BASE + 2 * ch;
  endfunction

  function automatic int unsigned cmp_lo_addr(input int unsigned ch);
    return A_CMP_BASE + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      past_ok <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      past_ok <= 1'b1;
    end
  end

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4,
  parameter int CH     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dis,
  output logic              hit,
  output logic [CNT_W-1:0]  cmp_val
);
  localparam int HI_W = CNT_W - WORD_W;
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(cmp_hi_addr(CH));
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(cmp_lo_addr(CH));

  logic [CNT_W-1:0] cmp_q;
  logic             inh_q;
  logic             hi_wr;
  logic             lo_wr;

  function automatic logic is_match(input logic [CNT_W-1:0] t,
                                    input logic [CNT_W-1:0] c,
                                    input logic blocked);
    return (t == c) && !blocked;
  endfunction

  assign hi_wr   = wr_en && (addr == HI_ADDR);
  assign lo_wr   = wr_en && (addr == LO_ADDR);
  assign hit     = is_match(cnt, cmp_q, dis || inh_q || hi_wr);
  assign cmp_val = cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      inh_q <= 1'b0;
    end else if (hi_wr) begin
      cmp_q[CNT_W-1:WORD_W] <= wdata[HI_W-1:0];
      inh_q                 <= 1'b1;
    end else if (lo_wr) begin
      cmp_q[WORD_W-1:0] <= wdata;
      inh_q             <= 1'b0;
    end
  end

  p_hi_sets_inh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> inh_q);
  p_inh_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inh_q |-> !hit);
  p_lo_no_inh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !inh_q) |=> !inh_q);
  p_hit_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4,
  parameter int NCH    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NCH-1:0]     wbits,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [NCH-1:0]     hit,
  input  logic [NCH*CNT_W-1:0] cmp_flat,
  output logic [NCH-1:0]     dis_eff,
  output logic [WORD_W-1:0]  rdata,
  output logic               irq
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [NCH-1:0]    mask_q;
  logic [NCH-1:0]    dis_q;
  logic [NCH-1:0]    status_q;
  logic [WORD_W-1:0] tlo_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rd_mux;
  logic              dis_wr;
  logic              mask_wr;
  logic              stat_rd;
  logic              thi_rd;
  logic [NCH-1:0]    status_nxt;

  function automatic logic [NCH-1:0] next_status(input logic [NCH-1:0] cur,
                                                 input logic [NCH-1:0] clr,
                                                 input logic [NCH-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  assign dis_wr  = wr_en && (addr == ADDR_W'(A_DIS));
  assign mask_wr = wr_en && (addr == ADDR_W'(A_MASK));
  assign stat_rd = rd_en && (addr == ADDR_W'(A_STAT));
  assign thi_rd  = rd_en && (addr == ADDR_W'(A_TIME_HI));
  assign dis_eff = dis_wr ? wbits : dis_q;

  assign status_nxt = next_status(status_q,
                                  (stat_rd ? {NCH{1'b1}} : '0) | (dis_wr ? wbits : '0),
                                  hit);

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_TIME_HI)) rd_mux = WORD_W'(cnt[CNT_W-1:WORD_W]);
    else if (addr == ADDR_W'(A_TIME_LO)) rd_mux = tlo_q;
    else if (addr == ADDR_W'(A_MASK)) rd_mux = WORD_W'(mask_q);
    else if (addr == ADDR_W'(A_DIS)) rd_mux = WORD_W'(dis_q);
    else if (addr == ADDR_W'(A_STAT)) rd_mux = WORD_W'(status_q);
    else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (addr == ADDR_W'(cmp_hi_addr(ch)))
          rd_mux = WORD_W'(cmp_flat[ch*CNT_W+WORD_W +: HI_W]);
        else if (addr == ADDR_W'(cmp_lo_addr(ch)))
          rd_mux = cmp_flat[ch*CNT_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      dis_q    <= '0;
      status_q <= '0;
      tlo_q    <= '0;
      rdata_q  <= '0;
    end else begin
      status_q <= status_nxt;
      if (mask_wr) mask_q <= wbits;
      if (dis_wr)  dis_q  <= wbits;
      if (thi_rd)  tlo_q  <= cnt[WORD_W-1:0];
      if (rd_en)   rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
  assign irq   = |(status_q & mask_q);

  p_stat_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status_q & $past(hit)) == $past(hit)));
  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  p_dis_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> ((status_q & $past(wbits)) == '0));
  p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (hit == '0)) |=> (status_q == '0));
  p_tlo_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thi_rd |=> (tlo_q == $past(cnt[WORD_W-1:0])));
endmodule

// File: rtl/evt_timer_cmp.sv
module evt_timer_cmp #(
  parameter int CNT_W  = 24,
  parameter int WORD_W = 16,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq,
  output logic [NCH-1:0]    match_pulse
);
  logic [CNT_W-1:0]     cnt;
  logic [NCH-1:0]       hit;
  logic [NCH-1:0]       dis_eff;
  logic [NCH*CNT_W-1:0] cmp_flat;

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    evt_cmp_chan #(
      .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CH(g)
    ) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cnt(cnt), .dis(dis_eff[g]), .hit(hit[g]),
      .cmp_val(cmp_flat[g*CNT_W +: CNT_W])
    );
  end

  evt_regs #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NCH(NCH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wbits(wdata[NCH-1:0]), .cnt(cnt), .hit(hit), .cmp_flat(cmp_flat),
    .dis_eff(dis_eff), .rdata(rdata), .irq(irq)
  );

  assign match_pulse = hit;

  p_one_hot_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_pulse) |=> ((match_pulse & $past(match_pulse)) == '0));
endmodule

// File: tb/evt_timer_cmp_tb.sv
module evt_timer_cmp_tb;
  localparam int CW = 10, WW = 6, NC = 4, AW = 4;
  localparam int PER = 1 << CW;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic irq;
  logic [NC-1:0] match_pulse;
  logic [CW-1:0] m;
  int n_vec = 0, n_bad = 0;
  int tg, d, st, p, b;

  evt_timer_cmp #(.CNT_W(CW), .WORD_W(WW), .NCH(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .match_pulse(match_pulse)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) m <= '0;
    else m <= m + 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    wr_en = 1; addr = AW'(a); wdata = WW'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v, output int stamp);
    stamp = int'(m);
    rd_en = 1; addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    v = int'(rdata);
  endtask

  task automatic wait_until(input int v);
    while (int'(m) != v) @(negedge clk);
  endtask

  task automatic win(input int n, input int ch, input int tgt,
                     output int pulses, output int bad);
    pulses = 0; bad = 0;
    for (int i = 0; i < n; i++) begin
      if (match_pulse[ch] !== (int'(m) == tgt)) bad++;
      if ((match_pulse & ~(NC'(1) << ch)) != '0) bad++;
      if (match_pulse[ch]) pulses++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 irq in reset", int'(irq), 0);
    chk("R11 rdata in reset", int'(rdata), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R7 irq after reset", int'(irq), 0);
    rd(4, d, st);
    chk("R7 all channels flag at count 0", d, 15);
    rd(2, d, st);
    chk("R7 mask reset", d, 0);
    rd(3, d, st);
    chk("R7 disable reset", d, 0);
    wait_until(PER - 2);
    wait_until(1);
    wr(3, 15);
    rd(4, d, st);
    chk("R6 disable write clears flags", d, 0);
    rd(3, d, st);
    chk("R6 disable readback", d, 15);

    // R1 R9: split time reads
    for (int k = 0; k < 20; k++) begin
      int hv, lv, s2;
      rd(0, hv, st);
      rd(1, lv, s2);
      chk("R9 time upper", hv, (st >> WW) % (1 << (CW - WW)));
      chk("R9 time lower captured", lv, st % (1 << WW));
      chk("R1 counter step", (s2 - st + PER) % PER, 1);
      repeat (k * 37) @(negedge clk);
    end

    // R2 R5 R8 R10 R11: per-channel sweep
    for (int ch = 0; ch < NC; ch++) begin
      tg = (int'(m) + 40 + 37 * ch) % PER;
      wr(8 + 2 * ch, tg >> WW);
      wr(9 + 2 * ch, tg % (1 << WW));
      rd(8 + 2 * ch, d, st);
      chk("R11 compare upper readback", d, tg >> WW);
      rd(9 + 2 * ch, d, st);
      chk("R11 compare lower readback", d, tg % (1 << WW));
      wr(2, 1 << ch);
      wr(3, 15 & ~(1 << ch));
      win(2 * PER, ch, tg, p, b);
      chk("R2 pulse only on equal count", b, 0);
      chk("R10 one match per period", p, 2);
      chk("R5 irq with mask", int'(irq), 1);
      rd(4, d, st);
      chk("R8 status read value", d, 1 << ch);
      chk("R8 irq drops after read", int'(irq), 0);
    end

    // R5: unmasked status, no irq (channel 3 active)
    wr(2, 0);
    wait_until((tg + 1) % PER);
    chk("R5 no irq when masked off", int'(irq), 0);
    rd(4, d, st);
    chk("R5 status set while masked", d, 8);

    // R8: read collides with match
    wait_until(tg);
    rd(4, d, st);
    chk("R8 read before collision", d, 0);
    rd(4, d, st);
    chk("R8 same-cycle match wins", d, 8);

    // R3: upper write inhibits until lower write
    wr(14, tg >> WW);
    win(PER + 80, 3, -1, p, b);
    chk("R3 inhibited no pulse", p, 0);
    chk("R3 inhibited no stray", b, 0);
    wr(15, tg % (1 << WW));
    win(PER, 3, tg, p, b);
    chk("R3 resumes after lower write", p, 1);
    chk("R3 resumed timing", b, 0);

    // R4: lower-only write
    begin
      int nt;
      nt = (tg & ~((1 << WW) - 1)) | ((tg + 5) % (1 << WW));
      wr(15, (tg + 5) % (1 << WW));
      win(PER, 3, nt, p, b);
      chk("R4 lower-only one match", p, 1);
      chk("R4 lower-only timing", b, 0);
      rd(14, d, st);
      chk("R4 upper unchanged", d, tg >> WW);

      // R6: disable clears pending flag and stops matches
      wait_until((nt + 1) % PER);
      wr(3, 15);
      rd(4, d, st);
      chk("R6 flag cleared by disable", d, 0);
      win(PER + 10, 3, -1, p, b);
      chk("R6 disabled no match", p + b, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule